// File: doc/BRIEF.md
# Perpendicular Recording Mode Register

This block keeps the recording-mode setup of a floppy disk controller and turns it into the mode used for the drive that is selected. A command write loads two global bits, the write-gate-early bit and the wide-gap bit, and may also load one perpendicular flag for each drive. An overwrite-enable bit in the same command decides whether the flags are loaded.

From the stored bits, the selected drive number and the current data-rate code, the block reports one of three modes: conventional, perpendicular at 500 Kbps, or perpendicular at 1 Mbps. It also passes on a write precompensation code. For a conventional drive this is the programmed code. For a perpendicular drive it is zero. Changing the mode never changes the data rate. The data-rate code is only read, so that a drive flagged through its own bit picks its perpendicular variant.

Two resets act on the block. The hardware reset clears everything. The software reset clears only the two global bits, so the flags for each drive survive a controller soft reset.

Top module: `perp_mode_cfg`

## Requirements
- R1: After the hardware reset (`rst_n` low), every drive and every rate code resolves to mode 00 (conventional), and `precompOut` equals `precompIn`.
- R2: Every accepted command write loads the write-gate-early bit from `cmdWord[0]` and the wide-gap bit from `cmdWord[1]`. The result is visible at the outputs on the first clock edge after the write.
- R3: With write-gate-early = 1 and wide-gap = 1, every drive resolves to mode 10 (1 Mbps perpendicular) at every rate code.
- R4: With write-gate-early = 1 and wide-gap = 0, every drive resolves to mode 01 (500 Kbps perpendicular) at every rate code.
- R5: With wide-gap = 1 and write-gate-early = 0, every drive resolves to mode 00, whatever its own flag holds.
- R6: With both global bits 0, a drive whose flag is 1 resolves to mode 10 when `rateCode` is 3 and to mode 01 for any other rate code. A drive whose flag is 0 resolves to mode 00. Mode code 11 is never produced.
- R7: The flag for drive n is loaded from `cmdWord[2+n]`, and only when `cmdWord[6]` (overwrite enable) is 1. A command with `cmdWord[6]` = 0 leaves all the flags unchanged.
- R8: `precompOut` is 0 whenever the resolved mode is not 00, and it equals `precompIn` when the mode is 00.
- R9: `swRst` clears both global bits and leaves the drive flags unchanged. A command write in the same cycle as `swRst` is dropped completely.
- R10: The hardware reset also clears all drive flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| swRst | input | 1 | Synchronous software reset, clears the global bits only |
| cmdWr | input | 1 | Command write strobe |
| cmdWord | input | 7 | Command word: bit0 write-gate-early, bit1 wide-gap, bits5:2 drive flags, bit6 overwrite enable |
| driveSel | input | 2 | Number of the selected drive |
| rateCode | input | 2 | Programmed data-rate code, where 3 means 1 Mbps |
| precompIn | input | 3 | Programmed write precompensation code |
| modeOut | output | 2 | Resolved mode: 00 conventional, 01 500 Kbps perpendicular, 10 1 Mbps perpendicular |
| precompOut | output | 3 | Precompensation code to apply |

## Verification
The bench builds the block with its defaults: four drives, a 2-bit rate code with the fast code at 3, and a 3-bit precompensation code. This configuration is small enough to cover the full space.

The bench writes all 128 command words in turn. After each write it sweeps every drive, every rate code and every precompensation value. The sequence therefore reaches every combination of global bits against every pattern of drive flags, including words with the overwrite bit clear, where the previous flags must survive.

Directed sequences then cover the software reset, a software reset that lands on the same edge as a command, and a hardware reset issued while flags are set.

// File: rtl/perp_pkg.sv
package perp_pkg;

  typedef enum logic [1:0] {
    MODE_CONV = 2'b00,
    MODE_P500 = 2'b01,
    MODE_P1M  = 2'b10
  } perpMode_e;

  // Command word field positions (drive n flag at CMD_DRV_LSB + n)
  localparam int CMD_WGE_BIT = 0;
  localparam int CMD_GAP_BIT = 1;
  localparam int CMD_DRV_LSB = 2;

  typedef struct packed {
    logic loadGlobal;
    logic loadDrives;
    logic clearGlobal;
  } ctrlStrobe_t;

endpackage

// File: rtl/perp_ctrl.sv
module perp_ctrl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 swRst,
  input  logic                 cmdWr,
  input  logic                 owBit,
  output perp_pkg::ctrlStrobe_t strb
);
  import perp_pkg::*;

  always_comb begin
    strb.clearGlobal = swRst;
    strb.loadGlobal  = cmdWr && !swRst;
    strb.loadDrives  = cmdWr && !swRst && owBit;
  end

  // Software reset and a command load never act together
  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.loadGlobal, strb.clearGlobal}));

  // Flags only load inside an accepted command
  assert_drive_load_in_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadDrives |-> strb.loadGlobal);

endmodule

// File: rtl/perp_dp.sv
module perp_dp #(
  parameter int NUM_DRIVES = 4,
  parameter int RATE_W     = 2,
  parameter int PRECOMP_W  = 3,
  parameter int FAST_RATE  = 3,
  localparam int DSEL_W    = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  perp_pkg::ctrlStrobe_t strb,
  input  logic                  cmdWge,
  input  logic                  cmdGap,
  input  logic                  cmdOw,
  input  logic [NUM_DRIVES-1:0] cmdDrv,
  input  logic [DSEL_W-1:0]     driveSel,
  input  logic [RATE_W-1:0]     rateCode,
  input  logic [PRECOMP_W-1:0]  precompIn,
  output logic [1:0]            modeOut,
  output logic [PRECOMP_W-1:0]  precompOut
);
  import perp_pkg::*;

  logic                  wgeQ;
  logic                  gapQ;
  logic [NUM_DRIVES-1:0] drvQ;
  perpMode_e             driveMode [NUM_DRIVES];
  perpMode_e             selMode;
  perpMode_e             rateVariant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wgeQ <= 1'b0;
      gapQ <= 1'b0;
    end else if (strb.clearGlobal) begin
      wgeQ <= 1'b0;
      gapQ <= 1'b0;
    end else if (strb.loadGlobal) begin
      wgeQ <= cmdWge;
      gapQ <= cmdGap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               drvQ <= '0;
    else if (strb.loadDrives) drvQ <= cmdDrv;
  end

  assign rateVariant = (rateCode == RATE_W'(FAST_RATE)) ? MODE_P1M : MODE_P500;

  for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drive
    always_comb begin
      if (wgeQ)                driveMode[i] = gapQ ? MODE_P1M : MODE_P500;
      else if (gapQ)           driveMode[i] = MODE_CONV;
      else if (drvQ[i])        driveMode[i] = rateVariant;
      else                     driveMode[i] = MODE_CONV;
    end
  end

  assign selMode    = driveMode[driveSel];
  assign modeOut    = selMode;
  assign precompOut = (selMode == MODE_CONV) ? precompIn : '0;

  assert_swrst_keeps_drives_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearGlobal |=> $stable(drvQ));

  assert_swrst_clears_global_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearGlobal |=> (!wgeQ && !gapQ));

  assert_no_ow_keeps_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadGlobal && !cmdOw) |=> $stable(drvQ));

  assert_perp_zero_precomp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOut != 2'b00) |-> (precompOut == '0));

  assert_mode_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    modeOut != 2'b11);

  assert_fast_global_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wgeQ && gapQ) |-> (modeOut == 2'b10));

endmodule

// File: rtl/perp_mode_cfg.sv
module perp_mode_cfg #(
  parameter int NUM_DRIVES = 4,
  parameter int RATE_W     = 2,
  parameter int PRECOMP_W  = 3,
  parameter int FAST_RATE  = 3,
  localparam int DSEL_W    = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
  localparam int CMD_W     = perp_pkg::CMD_DRV_LSB + NUM_DRIVES + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 swRst,
  input  logic                 cmdWr,
  input  logic [CMD_W-1:0]     cmdWord,
  input  logic [DSEL_W-1:0]    driveSel,
  input  logic [RATE_W-1:0]    rateCode,
  input  logic [PRECOMP_W-1:0] precompIn,
  output logic [1:0]           modeOut,
  output logic [PRECOMP_W-1:0] precompOut
);
  import perp_pkg::*;

  localparam int OW_BIT = CMD_W - 1;

  ctrlStrobe_t strb;

  perp_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .swRst (swRst),
    .cmdWr (cmdWr),
    .owBit (cmdWord[OW_BIT]),
    .strb  (strb)
  );

  perp_dp #(
    .NUM_DRIVES (NUM_DRIVES),
    .RATE_W     (RATE_W),
    .PRECOMP_W  (PRECOMP_W),
    .FAST_RATE  (FAST_RATE)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .cmdWge     (cmdWord[CMD_WGE_BIT]),
    .cmdGap     (cmdWord[CMD_GAP_BIT]),
    .cmdOw      (cmdWord[OW_BIT]),
    .cmdDrv     (cmdWord[CMD_DRV_LSB +: NUM_DRIVES]),
    .driveSel   (driveSel),
    .rateCode   (rateCode),
    .precompIn  (precompIn),
    .modeOut    (modeOut),
    .precompOut (precompOut)
  );

endmodule

// File: tb/perp_mode_cfg_bench.sv
`timescale 1ns/1ps
module perp_mode_cfg_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       swRst = 1'b0;
  logic       cmdWr = 1'b0;
  logic [6:0] cmdWord = '0;
  logic [1:0] driveSel = '0;
  logic [1:0] rateCode = '0;
  logic [2:0] precompIn = '0;
  logic [1:0] modeOut;
  logic [2:0] precompOut;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 1'b0;

  // Bench model of the stored state
  bit       mWge = 0, mGap = 0;
  bit [3:0] mDrv = 0;

  always #4 clk = ~clk;

  perp_mode_cfg u_perp_mode_cfg (
    .clk(clk), .rst_n(rst_n), .swRst(swRst), .cmdWr(cmdWr), .cmdWord(cmdWord),
    .driveSel(driveSel), .rateCode(rateCode), .precompIn(precompIn),
    .modeOut(modeOut), .precompOut(precompOut)
  );

  function automatic logic [1:0] expMode(int d, int r);
    if (mWge)     return mGap ? 2'b10 : 2'b01;
    if (mGap)     return 2'b00;
    if (mDrv[d])  return (r == 3) ? 2'b10 : 2'b01;
    return 2'b00;
  endfunction

  function automatic string stateTag();
    if (mWge && mGap) return "R3";
    if (mWge)         return "R4";
    if (mGap)         return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Sweep every drive, rate and precomp code
  task automatic sweep(string tag);
    for (int d = 0; d < 4; d++)
      for (int r = 0; r < 4; r++)
        for (int p = 0; p < 8; p++) begin
          logic [1:0] em;
          driveSel = 2'(d); rateCode = 2'(r); precompIn = 3'(p);
          #0.5;
          em = expMode(d, r);
          check(tag, {2'b00, modeOut}, {2'b00, em});
          check("R8", {1'b0, precompOut}, (em == 2'b00) ? {1'b0, 3'(p)} : 4'h0);
        end
  endtask

  task automatic writeCmd(logic [6:0] w, bit withSw);
    @(negedge clk);
    cmdWr = 1'b1; cmdWord = w; swRst = withSw;
    @(negedge clk);
    cmdWr = 1'b0; swRst = 1'b0;
    if (withSw) begin
      mWge = 0; mGap = 0;
    end else begin
      mWge = w[0]; mGap = w[1];
      if (w[6]) mDrv = w[5:2];
    end
  endtask

  task automatic softReset();
    @(negedge clk); swRst = 1'b1;
    @(negedge clk); swRst = 1'b0;
    mWge = 0; mGap = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1");

    // R2: global bits load on the write
    writeCmd(7'h03, 0);
    sweep("R2");

    // Full sweep of all command words
    for (int c = 0; c < 128; c++) begin
      writeCmd(7'(c), 0);
      sweep(stateTag());
    end

    // R7: overwrite bit clear keeps previous flags
    writeCmd(7'h40 | 7'(4'b0101 << 2), 0);
    writeCmd(7'(4'b1010 << 2), 0);
    sweep("R7");

    // R9: software reset clears globals, keeps flags
    writeCmd(7'h40 | 7'(4'b0110 << 2) | 7'h03, 0);
    softReset();
    sweep("R9");

    // R9: command coinciding with software reset is dropped
    writeCmd(7'h7F, 1);
    sweep("R9");

    // R10: hardware reset clears flags too
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    mWge = 0; mGap = 0; mDrv = 0;
    sweep("R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule